// File: doc/BRIEF.md
# Packet Router Header and Parity Register Bank

This unit is the datapath register stage of a byte-stream packet router with one input and three outputs. A packet is a header byte, then payload bytes while `pkt_valid` is high, then one parity byte presented on the cycle after `pkt_valid` goes low. A separate controller walks each packet through its states and drives four one-hot strobes into this unit. The strobes mark the start of a packet, the release of the header, body byte loading, and the replay of a stalled byte.

The unit owns four byte registers: the captured header, a single-byte hold used while the destination FIFO is full, the parity it accumulates itself, and the parity byte received with the packet. From these it produces the registered byte for the FIFO write path, a parity-done flag, a parity-error flag, and a one-cycle low-packet-valid pulse. The controller uses that pulse to leave its data-loading state.

Top module: `pkt_regbank`

## Requirements
- R1: After a synchronous active-low reset, `dout`, `parity_done`, `parity_err` and `low_pkt_valid` are all 0.
- R2: A cycle with `st_addr` and `pkt_valid` both high captures `din` as the header. With `pkt_valid` low, `st_addr` leaves the header unchanged. A following `st_first` puts the stored header on `dout` one edge later.
- R3: A cycle with `st_data` high and `fifo_full` low puts `din` on `dout` after that edge.
- R4: A cycle with `st_data` and `fifo_full` both high leaves `dout` unchanged and stores `din` in the hold register. A later `st_after_full` puts the held byte on `dout` one edge later.
- R5: Internal parity is cleared by `st_addr`. It XORs in the header at `st_first` and each byte loaded under `st_data` while `pkt_valid` is high, whether or not the FIFO is full. The parity byte is never included.
- R6: A byte loaded under `st_data` while `pkt_valid` is low is the packet parity byte. Two edges after that cycle, `parity_done` is 1, and `parity_err` is 1 exactly when internal parity differs from that byte. `parity_err` is never 1 while `parity_done` is 0.
- R7: `low_pkt_valid` is 1 for exactly one cycle after an edge where `st_data` is high, `pkt_valid` is low, and `pkt_valid` was high in the cycle before.
- R8: `st_addr` clears `parity_done` and `parity_err` at the next edge.
- R9: The strobes are mutually exclusive. In a cycle with no strobe, `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | High while header and payload bytes are presented |
| din | input | DATA_W | Incoming byte stream |
| fifo_full | input | 1 | Destination FIFO cannot take a byte this cycle |
| st_addr | input | 1 | Controller strobe: packet start, header capture |
| st_first | input | 1 | Controller strobe: release header to `dout` |
| st_data | input | 1 | Controller strobe: load a body byte (payload or parity) |
| st_after_full | input | 1 | Controller strobe: replay the held byte |
| dout | output | DATA_W | Registered byte toward the FIFOs |
| parity_done | output | 1 | Parity comparison complete for this packet |
| parity_err | output | 1 | Internal and received parity differ |
| low_pkt_valid | output | 1 | One-cycle pulse when `pkt_valid` drops during loading |

## Verification
The parity byte can arrive while the FIFO is full. In that single cycle, three things happen together: the byte is latched as packet parity, it is stored in the hold register, and the low-packet-valid pulse is raised. The bench provokes this by holding `fifo_full` high across the falling edge of `pkt_valid`. The scoreboard then expects, in order, an unchanged `dout`, the one-cycle pulse, `parity_done` with the correct error value two edges on, and the parity byte on `dout` after `st_after_full`. A reference model built from the requirements predicts every cycle's outputs and compares them against the design.

// File: rtl/pkt_regbank_pkg.sv
// Package: shared controller-strobe type for the register bank.
// Assumes the controller raises at most one strobe per cycle.
package pkt_regbank_pkg;

    typedef struct packed {
        logic addr;        // packet start
        logic first;       // header release
        logic data;        // body byte load
        logic after_full;  // held byte replay
    } ctl_strobe_t;

endpackage

// File: rtl/pkt_hdr_hold.sv
// Header register, full-state hold register and output byte register.
// Assumes one-hot strobes; the output byte is registered (one edge latency).
module pkt_hdr_hold
    import pkt_regbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic              fifo_full,
    input  logic [DATA_W-1:0] din,
    input  ctl_strobe_t       stb,
    output logic [DATA_W-1:0] hdr_q,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] hold_q;

    // Capture the header byte at packet start while the packet is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hdr_q <= '0;
        else if (stb.addr && pkt_valid)
            hdr_q <= din;
    end

    // Park a body byte that arrives while the FIFO is full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (stb.data && fifo_full)
            hold_q <= din;
    end

    // Select the byte presented to the FIFO write path.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (stb.first)
            dout <= hdr_q;
        else if (stb.after_full)
            dout <= hold_q;
        else if (stb.data && !fifo_full)
            dout <= din;
    end

    AST_HDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.addr && pkt_valid) |=> (hdr_q == $past(din)));                 // R2
    AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.data && !fifo_full) |=> (dout == $past(din)));                 // R3
    AST_HOLD_KEEPS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.data && fifo_full) |=> $stable(dout));                         // R4
    AST_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        stb.after_full |=> (dout == $past(hold_q)));                        // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stb == '0) |=> $stable(dout));                                     // R9

endmodule

// File: rtl/pkt_parity_unit.sv
// Internal parity accumulator, received-parity register and the
// done/error flags. The comparison runs one edge after the parity byte
// is latched, so both flags appear two edges after that byte.
module pkt_parity_unit
    import pkt_regbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] hdr_q,
    input  ctl_strobe_t       stb,
    output logic              parity_done,
    output logic              parity_err
);

    logic [DATA_W-1:0] int_par_q;
    logic [DATA_W-1:0] pkt_par_q;
    logic              cmp_pend_q;

    // Accumulate XOR parity over header and payload bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_par_q <= '0;
        else if (stb.addr)
            int_par_q <= '0;
        else if (stb.first)
            int_par_q <= int_par_q ^ hdr_q;
        else if (stb.data && pkt_valid)
            int_par_q <= int_par_q ^ din;
    end

    // Latch the received parity byte and schedule the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_par_q  <= '0;
            cmp_pend_q <= 1'b0;
        end else begin
            if (stb.data && !pkt_valid)
                pkt_par_q <= din;
            cmp_pend_q <= stb.data && !pkt_valid && !stb.addr;
        end
    end

    // Publish the comparison result; packet start clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_done <= 1'b0;
            parity_err  <= 1'b0;
        end else if (stb.addr) begin
            parity_done <= 1'b0;
            parity_err  <= 1'b0;
        end else if (cmp_pend_q) begin
            parity_done <= 1'b1;
            parity_err  <= (int_par_q != pkt_par_q);
        end
    end

    AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        stb.addr |=> !parity_done);                                         // R8
    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> parity_done);                                        // R6
    AST_PAR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.data && !pkt_valid) |=> (pkt_par_q == $past(din)));            // R6

endmodule

// File: rtl/pkt_lowvalid_det.sv
// Detects the fall of pkt_valid while body bytes are loading and emits a
// one-cycle registered pulse.
module pkt_lowvalid_det
    import pkt_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pkt_valid,
    input  ctl_strobe_t stb,
    output logic        low_pkt_valid
);

    logic pv_d_q;

    // Remember last cycle's pkt_valid and flag its fall during loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_d_q        <= 1'b0;
            low_pkt_valid <= 1'b0;
        end else begin
            pv_d_q        <= pkt_valid;
            low_pkt_valid <= stb.data && pv_d_q && !pkt_valid;
        end
    end

    AST_LOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        low_pkt_valid |=> !low_pkt_valid);                                  // R7
    AST_LOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        low_pkt_valid |-> !$past(pkt_valid));                               // R7

endmodule

// File: rtl/pkt_regbank.sv
// Top of the router register bank. Bundles the controller strobes and
// wires the header/hold path, parity unit and low-valid detector.
// Assumes the controller raises at most one strobe per cycle.
module pkt_regbank
    import pkt_regbank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [DATA_W-1:0] din,
    input  logic              fifo_full,
    input  logic              st_addr,
    input  logic              st_first,
    input  logic              st_data,
    input  logic              st_after_full,
    output logic [DATA_W-1:0] dout,
    output logic              parity_done,
    output logic              parity_err,
    output logic              low_pkt_valid
);

    ctl_strobe_t       stb;
    logic [DATA_W-1:0] hdr_q;

    // Gather the strobes into one bundle.
    always_comb begin
        stb.addr       = st_addr;
        stb.first      = st_first;
        stb.data       = st_data;
        stb.after_full = st_after_full;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_addr, st_first, st_data, st_after_full}));             // R9

    pkt_hdr_hold #(.DATA_W(DATA_W)) u_hdr_hold (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .fifo_full(fifo_full),
        .din(din), .stb(stb), .hdr_q(hdr_q), .dout(dout)
    );

    pkt_parity_unit #(.DATA_W(DATA_W)) u_parity (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .din(din),
        .hdr_q(hdr_q), .stb(stb), .parity_done(parity_done),
        .parity_err(parity_err)
    );

    pkt_lowvalid_det u_lowvalid (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .stb(stb),
        .low_pkt_valid(low_pkt_valid)
    );

endmodule

// File: tb/pkt_regbank_tb_top.sv
// Scoreboard bench: the driver predicts each edge's outputs from the
// requirements and queues them; the monitor compares after each edge.
module pkt_regbank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_valid = 1'b0;
    logic [7:0] din = '0;
    logic       fifo_full = 1'b0;
    logic       st_addr = 1'b0, st_first = 1'b0, st_data = 1'b0, st_after_full = 1'b0;
    logic [7:0] dout;
    logic       parity_done, parity_err, low_pkt_valid;

    int n_total = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    typedef struct {
        logic [7:0] d;
        logic       dn;
        logic       er;
        logic       lo;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    // Reference model state
    logic [7:0] m_hdr = '0, m_hold = '0, m_dout = '0, m_int = '0, m_pkt = '0;
    logic       m_chk = 0, m_done = 0, m_err = 0, m_low = 0, m_pvd = 0;

    always #10 clk = ~clk;  // 50 MHz

    pkt_regbank #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .din(din),
        .fifo_full(fifo_full), .st_addr(st_addr), .st_first(st_first),
        .st_data(st_data), .st_after_full(st_after_full), .dout(dout),
        .parity_done(parity_done), .parity_err(parity_err),
        .low_pkt_valid(low_pkt_valid)
    );

    task automatic drive(input logic sa, input logic sf, input logic sd,
                         input logic saf, input logic pv, input logic fl,
                         input logic [7:0] d, input string req);
        logic [7:0] n_hdr, n_hold, n_dout, n_int, n_pkt;
        logic       n_chk, n_done, n_err, n_low;
        exp_t       e;
        @(negedge clk);
        st_addr = sa; st_first = sf; st_data = sd; st_after_full = saf;
        pkt_valid = pv; fifo_full = fl; din = d;
        n_hdr  = (sa && pv) ? d : m_hdr;
        n_dout = sf ? m_hdr : saf ? m_hold : (sd && !fl) ? d : m_dout;
        n_hold = (sd && fl) ? d : m_hold;
        n_int  = sa ? 8'h00 : sf ? (m_int ^ m_hdr) : (sd && pv) ? (m_int ^ d) : m_int;
        n_pkt  = (sd && !pv) ? d : m_pkt;
        n_chk  = sd && !pv && !sa;
        n_done = m_done; n_err = m_err;
        if (sa) begin n_done = 0; n_err = 0; end
        else if (m_chk) begin n_done = 1; n_err = (m_int != m_pkt); end
        n_low  = sd && m_pvd && !pv;
        m_hdr = n_hdr; m_dout = n_dout; m_hold = n_hold; m_int = n_int;
        m_pkt = n_pkt; m_chk = n_chk; m_done = n_done; m_err = n_err;
        m_low = n_low; m_pvd = pv;
        e.d = n_dout; e.dn = n_done; e.er = n_err; e.lo = n_low; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input logic pv, input logic fl, input string req);
        drive(0, 0, 0, 0, pv, fl, 8'h00, req);
    endtask

    // Monitor: compare each edge's outputs with the queued prediction.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_total++;
                if (dout !== e.d || parity_done !== e.dn ||
                    parity_err !== e.er || low_pkt_valid !== e.lo) begin
                    n_fail++;
                    $display("FAIL %s: dout=%h done=%b err=%b low=%b expected dout=%h done=%b err=%b low=%b",
                             e.req, dout, parity_done, parity_err, low_pkt_valid,
                             e.d, e.dn, e.er, e.lo);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        n_total++;
        if (dout !== 8'h00 || parity_done !== 0 || parity_err !== 0 || low_pkt_valid !== 0) begin
            n_fail++;
            $display("FAIL R1: dout=%h done=%b err=%b low=%b expected all zero",
                     dout, parity_done, parity_err, low_pkt_valid);
        end
        idle(0, 0, "R9");
        idle(0, 0, "R9");
        // Packet with correct parity
        drive(1, 0, 0, 0, 1, 0, 8'h05, "R2");
        drive(0, 1, 0, 0, 1, 0, 8'h00, "R2");
        drive(0, 0, 1, 0, 1, 0, 8'h11, "R3");
        idle(1, 0, "R9");
        drive(0, 0, 1, 0, 1, 0, 8'h22, "R3");
        drive(0, 0, 1, 0, 0, 0, 8'h05 ^ 8'h11 ^ 8'h22, "R7");
        idle(0, 0, "R6");
        idle(0, 0, "R6");
        // Packet with wrong parity; start clears done
        drive(1, 0, 0, 0, 1, 0, 8'h9C, "R8");
        drive(0, 1, 0, 0, 1, 0, 8'h00, "R2");
        drive(0, 0, 1, 0, 1, 0, 8'h41, "R3");
        drive(0, 0, 1, 0, 0, 0, 8'h00, "R7");
        idle(0, 0, "R6");
        idle(0, 0, "R6");
        // Start without pkt_valid: header kept, error cleared
        drive(1, 0, 0, 0, 0, 0, 8'hAA, "R8");
        drive(0, 1, 0, 0, 0, 0, 8'h00, "R2");
        // Packet with backpressure, parity byte arriving while full
        drive(1, 0, 0, 0, 1, 0, 8'h3C, "R2");
        drive(0, 1, 0, 0, 1, 0, 8'h00, "R2");
        drive(0, 0, 1, 0, 1, 1, 8'h77, "R4");
        idle(1, 1, "R4");
        drive(0, 0, 0, 1, 1, 0, 8'h00, "R4");
        drive(0, 0, 1, 0, 1, 0, 8'h18, "R3");
        drive(0, 0, 1, 0, 0, 1, 8'h3C ^ 8'h77 ^ 8'h18, "R5");
        idle(0, 1, "R5");
        drive(0, 0, 0, 1, 0, 0, 8'h00, "R4");
        idle(0, 0, "R6");
        // Low pulse only on a fall: parity byte without a prior valid cycle
        drive(1, 0, 0, 0, 0, 0, 8'h00, "R8");
        drive(0, 0, 1, 0, 0, 0, 8'h5A, "R7");
        idle(0, 0, "R7");
        idle(0, 0, "R6");
        repeat (3) @(posedge clk);
        #5;
        done_flag = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule